// File: doc/BRIEF.md
# Programmable Memory Select Decoder

This block sits on the processor's memory bus. It turns each access address into one memory-select line, chosen from a small bank of programmable channels. Each channel describes one region of the address space. The description is a 22-bit base address held across two configuration words, a 4-bit logarithmic size code from 1 KB to 16 MB, a map enable, and two protection flags. One flag makes the region read-only. The other admits only privileged-mode accesses.

Every bus access is compared against all active regions in parallel. When regions overlap, the lowest-numbered matching channel wins. An access that breaks the winning region's protection does not reach memory. Instead the block raises a one-cycle illegal-access pulse and records the offending address and access type in a status pair that software can read back. All bus-side outputs are registered, so they appear in the cycle after the access is presented.

The configuration port is a single-cycle word write with a combinational word read.

Top module: `memsel_decoder`

## Requirements
- R1: After reset, every configuration and status word reads 0, and mem_sel, wr_strobe and illegal_access are all 0.
- R2: A channel whose map enable is 1 and whose size code k is nonzero matches when bus_addr[31:9+k] equals base[21:k-1]. Its select bit is driven in the cycle after the access.
- R3: A channel with map enable 0, or with size code 0, never matches.
- R4: Size code k gives a region of 2^(9+k) bytes, so code 1 is 1 KB and code 15 is 16 MB. Base bits below the region size are ignored, which aligns every region to its size.
- R5: When several channels match, only the lowest-numbered one is selected. mem_sel never has more than one bit set.
- R6: A write that hits a read-only region raises illegal_access. Reads of that region are selected normally.
- R7: A user-mode access (bus_priv = 0) that hits a privileged-only region raises illegal_access. Privileged accesses are selected normally.
- R8: In a cycle where illegal_access is 1, mem_sel is 0 and wr_strobe is 0.
- R9: wr_strobe is 1 exactly for a valid, permitted write that hits a region. It always comes with a select bit.
- R10: The register map is as follows.
  - Word 2c is channel c's control word: bits 15:10 base[5:0], bit 8 map enable, bits 7:4 size code, bit 1 read-only, bit 0 privileged-only.
  - Word 2c+1 holds base[21:6] in bits 15:0.
  - All other bits read 0.
  - Writes to the status words are ignored.
- R11: Each illegal access stores its address in word 2N (N channels). It also stores, in word 2N+1, bit 0 = access was a write, bit 1 = access was user mode, and bit 2 = set once any fault has been recorded. The status reads back in the same cycle as the pulse.
- R12: With bus_valid 0, the next cycle shows no select, no write strobe and no exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration word write enable |
| cfg_addr | input | CFG_AW | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for cfg_addr (combinational) |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_addr | input | 32 | Byte address of the access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| mem_sel | output | NUM_CH | One-hot memory select, registered |
| wr_strobe | output | 1 | Permitted write passed to memory, registered |
| illegal_access | output | 1 | One-cycle protection violation pulse |

## Verification
The bench places overlapping regions of different sizes at the same base, so a decoder with the wrong priority order selects the larger, higher-numbered channel. It uses misaligned base values, so a decoder that compares base bits below the region size misses accesses in the upper part of the region. It also probes addresses one byte past each region's end, where an off-by-one in the size mask widens or narrows the region.

Protection cases pair reads with writes and user accesses with privileged ones. A design that forgets to block a violating access shows a select or a write strobe alongside the exception. One that checks protection on the wrong channel faults on a permitted access. Disabled channels, size code 0 and writes to the status words are checked for having no effect.

// File: rtl/memsel_pkg.sv
`timescale 1ns/1ps
package memsel_pkg;
    localparam int ADDR_W = 32;
    localparam int BASE_W = 22;
    localparam int PAGE_W = ADDR_W - BASE_W;
    localparam int REG_W  = 32;

    typedef struct packed {
        logic [5:0] base_lo;
        logic       map_en;
        logic [3:0] size_code;
        logic       ronly;
        logic       priv_only;
    } ctrl_t;

    typedef struct packed {
        ctrl_t       ctrl;
        logic [15:0] base_hi;
    } chan_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              was_user;
        logic              was_write;
        logic              seen;
    } fault_rec_t;

    function automatic logic [REG_W-1:0] ctrl_to_word(ctrl_t c);
        logic [REG_W-1:0] w;
        w        = '0;
        w[15:10] = c.base_lo;
        w[8]     = c.map_en;
        w[7:4]   = c.size_code;
        w[1]     = c.ronly;
        w[0]     = c.priv_only;
        return w;
    endfunction

    function automatic ctrl_t word_to_ctrl(logic [REG_W-1:0] w);
        ctrl_t c;
        c.base_lo   = w[15:10];
        c.map_en    = w[8];
        c.size_code = w[7:4];
        c.ronly     = w[1];
        c.priv_only = w[0];
        return c;
    endfunction

    function automatic logic [BASE_W-1:0] full_base(chan_cfg_t c);
        return {c.base_hi, c.ctrl.base_lo};
    endfunction

    // Region match: compare only base bits at or above the region size.
    function automatic logic region_hit(chan_cfg_t c, logic [ADDR_W-1:0] a);
        logic [BASE_W-1:0] care;
        care = {BASE_W{1'b1}} << (c.ctrl.size_code - 4'd1);
        return c.ctrl.map_en && (c.ctrl.size_code != 4'd0) &&
               (((a[ADDR_W-1:PAGE_W] ^ full_base(c)) & care) == '0);
    endfunction
endpackage

// File: rtl/memsel_regs.sv
`timescale 1ns/1ps
module memsel_regs
    import memsel_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CFG_AW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [CFG_AW-1:0]        cfg_addr,
    input  logic [REG_W-1:0]         cfg_wdata,
    output logic [REG_W-1:0]         cfg_rdata,
    input  logic                     fault_evt,
    input  logic [ADDR_W-1:0]        fault_addr,
    input  logic                     fault_write,
    input  logic                     fault_user,
    output chan_cfg_t [NUM_CH-1:0]   chan_cfg
);
    localparam int CFG_WORDS = 2 * NUM_CH;
    localparam int STAT_ADDR = CFG_WORDS;
    localparam int STAT_INFO = CFG_WORDS + 1;

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] chan;
        fault_rec_t             fault;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (cfg_wr) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (int'(cfg_addr) == 2 * c)
                    regs_d.chan[c].ctrl = word_to_ctrl(cfg_wdata);
                else if (int'(cfg_addr) == 2 * c + 1)
                    regs_d.chan[c].base_hi = cfg_wdata[15:0];
            end
        end
        if (fault_evt) begin
            regs_d.fault.addr      = fault_addr;
            regs_d.fault.was_write = fault_write;
            regs_d.fault.was_user  = fault_user;
            regs_d.fault.seen      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        cfg_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(cfg_addr) == 2 * c)
                cfg_rdata = ctrl_to_word(regs_q.chan[c].ctrl);
            else if (int'(cfg_addr) == 2 * c + 1)
                cfg_rdata = {{(REG_W-16){1'b0}}, regs_q.chan[c].base_hi};
        end
        if (int'(cfg_addr) == STAT_ADDR)
            cfg_rdata = regs_q.fault.addr;
        else if (int'(cfg_addr) == STAT_INFO)
            cfg_rdata = {{(REG_W-3){1'b0}}, regs_q.fault.seen,
                         regs_q.fault.was_user, regs_q.fault.was_write};
    end

    assign chan_cfg = regs_q.chan;

    // R11
    fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_evt |=> (regs_q.fault.seen && regs_q.fault.addr == $past(fault_addr)));

    // R10
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && int'(cfg_addr) >= CFG_WORDS && !fault_evt) |=> $stable(regs_q.fault));
endmodule

// File: rtl/memsel_match.sv
`timescale 1ns/1ps
module memsel_match
    import memsel_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  chan_cfg_t [NUM_CH-1:0] chan_cfg,
    input  logic [ADDR_W-1:0]      addr,
    output logic                   hit_any,
    output logic [NUM_CH-1:0]      win_sel,
    output logic                   win_ronly,
    output logic                   win_priv
);
    logic [NUM_CH-1:0] raw_hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign raw_hit[g] = region_hit(chan_cfg[g], addr);
    end

    // Scan from the top so the lowest-numbered hit is written last and wins.
    always_comb begin
        win_sel   = '0;
        win_ronly = 1'b0;
        win_priv  = 1'b0;
        for (int c = NUM_CH - 1; c >= 0; c--) begin
            if (raw_hit[c]) begin
                win_sel    = '0;
                win_sel[c] = 1'b1;
                win_ronly  = chan_cfg[c].ctrl.ronly;
                win_priv   = chan_cfg[c].ctrl.priv_only;
            end
        end
    end

    assign hit_any = |raw_hit;
endmodule

// File: rtl/memsel_decoder.sv
`timescale 1ns/1ps
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int CFG_AW = $clog2(2 * NUM_CH + 2)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [REG_W-1:0]    cfg_wdata,
    output logic [REG_W-1:0]    cfg_rdata,
    input  logic                bus_valid,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_write,
    input  logic                bus_priv,
    output logic [NUM_CH-1:0]   mem_sel,
    output logic                wr_strobe,
    output logic                illegal_access
);
    typedef struct packed {
        logic [NUM_CH-1:0] sel;
        logic              wr;
        logic              illegal;
    } out_t;

    chan_cfg_t [NUM_CH-1:0] chan_cfg;
    logic                   hit_any;
    logic [NUM_CH-1:0]      win_sel;
    logic                   win_ronly;
    logic                   win_priv;
    logic                   hit_d;
    logic                   viol_d;
    out_t                   out_d, out_q;

    memsel_regs #(.NUM_CH(NUM_CH), .CFG_AW(CFG_AW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .fault_evt  (viol_d),
        .fault_addr (bus_addr),
        .fault_write(bus_write),
        .fault_user (~bus_priv),
        .chan_cfg   (chan_cfg)
    );

    memsel_match #(.NUM_CH(NUM_CH)) match_i (
        .chan_cfg (chan_cfg),
        .addr     (bus_addr),
        .hit_any  (hit_any),
        .win_sel  (win_sel),
        .win_ronly(win_ronly),
        .win_priv (win_priv)
    );

    always_comb begin
        hit_d       = bus_valid && hit_any;
        viol_d      = hit_d && ((bus_write && win_ronly) || (!bus_priv && win_priv));
        out_d       = '0;
        out_d.sel   = (hit_d && !viol_d) ? win_sel : '0;
        out_d.wr    = hit_d && !viol_d && bus_write;
        out_d.illegal = viol_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign mem_sel        = out_q.sel;
    assign wr_strobe      = out_q.wr;
    assign illegal_access = out_q.illegal;

    // R5
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_q.sel));

    // R8
    fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.illegal |-> (out_q.sel == '0 && !out_q.wr));

    // R9
    wr_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.wr |-> ((|out_q.sel) && $past(bus_write)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> (out_q.sel == '0 && !out_q.wr && !out_q.illegal));

    // R6
    ronly_read_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_priv && hit_any) |=> (!out_q.illegal && (|out_q.sel)));
endmodule

// File: tb/memsel_decoder_tb_top.sv
`timescale 1ns/1ps
module memsel_decoder_tb_top;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_write = 1'b0;
    logic        bus_priv = 1'b0;
    logic [3:0]  mem_sel;
    logic        wr_strobe;
    logic        illegal_access;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [21:0] m_base [NCH];
    logic        m_en   [NCH];
    logic [3:0]  m_size [NCH];
    logic        m_ro   [NCH];
    logic        m_pv   [NCH];
    logic [31:0] st_addr = '0;
    logic [31:0] st_info = '0;

    always #2 clk = ~clk;

    memsel_decoder #(.NUM_CH(NCH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_write(bus_write), .bus_priv(bus_priv),
        .mem_sel(mem_sel), .wr_strobe(wr_strobe), .illegal_access(illegal_access)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 4'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input int idx, output logic [31:0] v);
        @(negedge clk);
        cfg_addr = 4'(idx);
        #1 v = cfg_rdata;
    endtask

    task automatic program_ch(input int ch, input logic [21:0] base, input logic en,
                              input logic [3:0] sz, input logic ro, input logic pv);
        cfg_write(2 * ch, {16'h0, base[5:0], 1'b0, en, sz, 2'b00, ro, pv});
        cfg_write(2 * ch + 1, {16'h0, base[21:6]});
        m_base[ch] = base; m_en[ch] = en; m_size[ch] = sz; m_ro[ch] = ro; m_pv[ch] = pv;
    endtask

    // Expected decode from R2-R7: lowest matching channel, then protection.
    function automatic int model_ch(input logic [31:0] a);
        int ch = -1;
        for (int c = NCH - 1; c >= 0; c--)
            if (m_en[c] && m_size[c] != 0 &&
                (((a[31:10] ^ m_base[c]) & (22'h3FFFFF << (m_size[c] - 4'd1))) == 22'h0))
                ch = c;
        return ch;
    endfunction

    task automatic access(input logic [31:0] a, input logic w, input logic p, input string req);
        int ch;
        logic bad;
        logic [3:0] e_sel;
        logic e_wr;
        logic [31:0] v;
        ch = model_ch(a);
        bad = (ch >= 0) && ((w && m_ro[ch]) || (!p && m_pv[ch]));
        e_sel = (ch >= 0 && !bad) ? 4'(1 << ch) : 4'h0;
        e_wr = (ch >= 0) && !bad && w;
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = a; bus_write = w; bus_priv = p;
        @(negedge clk);
        bus_valid = 1'b0;
        check({req, " R5 sel"}, 32'(mem_sel), 32'(e_sel));
        check({req, " R9 wr"}, 32'(wr_strobe), 32'(e_wr));
        check({req, " R8 illegal"}, 32'(illegal_access), 32'(bad));
        if (bad) begin
            st_addr = a;
            st_info = {29'h0, 1'b1, !p, w};
            cfg_addr = 4'(2 * NCH);
            #1 v = cfg_rdata;
            check("R11 fault addr", v, st_addr);
            cfg_addr = 4'(2 * NCH + 1);
            #1 v = cfg_rdata;
            check("R11 fault info", v, st_info);
        end
    endtask

    initial begin
        logic [31:0] v;
        for (int c = 0; c < NCH; c++) begin
            m_base[c] = '0; m_en[c] = 0; m_size[c] = 0; m_ro[c] = 0; m_pv[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int i = 0; i < 2 * NCH + 2; i++) begin
            cfg_read(i, v);
            check("R1 reset word", v, 32'h0);
        end
        check("R1 reset sel", {29'h0, mem_sel == 0, wr_strobe, illegal_access}, 32'h4);

        // R10 readback and unused bits
        cfg_write(0, 32'hFFFF_FFFF);
        cfg_read(0, v);
        check("R10 ctrl readback", v, 32'h0000_FDF3);
        cfg_write(1, 32'hFFFF_ABCD);
        cfg_read(1, v);
        check("R10 base high readback", v, 32'h0000_ABCD);

        // Directed regions
        program_ch(0, 22'h000010, 1, 4'd1, 0, 0);   // 1 KB at 0x4000
        program_ch(1, 22'h000020, 0, 4'd2, 0, 0);   // disabled
        program_ch(2, 22'h000013, 1, 4'd3, 0, 0);   // 4 KB, misaligned base -> 0x4000
        program_ch(3, 22'h000040, 1, 4'd5, 1, 0);   // 16 KB read-only at 0x10000

        access(32'h0000_4000, 0, 1, "R2 base hit");
        access(32'h0000_43FF, 1, 1, "R5 overlap low wins");
        access(32'h0000_4400, 0, 1, "R4 past 1KB end");
        access(32'h0000_4FFF, 1, 0, "R4 aligned top");
        access(32'h0000_5000, 0, 1, "R4 past 4KB end");
        access(32'h0000_8000, 0, 1, "R3 disabled");
        access(32'h0001_0000, 1, 1, "R6 ro write");
        access(32'h0001_3FFC, 0, 0, "R6 ro read");
        access(32'h0001_4000, 0, 1, "R4 past 16KB end");

        program_ch(1, 22'h000020, 1, 4'd0, 0, 0);   // enabled but size 0
        access(32'h0000_8000, 0, 1, "R3 size zero");

        program_ch(1, 22'h000080, 1, 4'd1, 0, 1);   // privileged only at 0x20000
        access(32'h0002_0000, 0, 0, "R7 user read");
        access(32'h0002_0004, 1, 1, "R7 priv write");
        access(32'h0002_03FC, 1, 0, "R7 user write");

        // R10 status words ignore writes
        cfg_write(2 * NCH, 32'hDEAD_BEEF);
        cfg_write(2 * NCH + 1, 32'hFFFF_FFFF);
        cfg_read(2 * NCH, v);
        check("R10 status addr kept", v, st_addr);
        cfg_read(2 * NCH + 1, v);
        check("R10 status info kept", v, st_info);

        // R12 idle with a hitting address
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = 32'h0000_4000; bus_write = 1'b1; bus_priv = 1'b0;
        @(negedge clk);
        check("R12 idle", {29'h0, mem_sel != 0, wr_strobe, illegal_access}, 32'h0);

        // R4 largest size
        program_ch(0, 22'h3C0000, 1, 4'd15, 0, 0);  // 16 MB at 0xF0000000
        access(32'hF0FF_FFFF, 0, 1, "R4 16MB top");
        access(32'hF100_0000, 0, 1, "R4 16MB past");

        // Constrained random
        void'($urandom(32'h5EED_0123));
        for (int r = 0; r < 40; r++) begin
            for (int c = 0; c < NCH; c++)
                program_ch(c, 22'($urandom) & 22'h00003F | 22'h000100, ($urandom % 4) != 0,
                           4'($urandom % 16), ($urandom % 4) == 0, ($urandom % 4) == 0);
            for (int k = 0; k < 20; k++) begin
                int pick;
                logic [31:0] msk;
                pick = $urandom % NCH;
                case ($urandom % 3)
                    0: msk = 32'h0000_03FF;
                    1: msk = 32'h0000_FFFF;
                    default: msk = 32'h000F_FFFF;
                endcase
                access({m_base[pick], 10'h0} ^ ($urandom & msk), 1'($urandom), 1'($urandom), "R2 random");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule